// File: doc/BRIEF.md
# Event-Driven Output and Interrupt Matrix

This block turns a vector of fired timer events into up to four timer output levels and one interrupt request. Each output has a set mask and a clear mask over the event inputs. Any event in an output's set mask drives that output high. Any event in its clear mask drives it low. One event can steer several outputs at once.

When the counter runs bidirectionally, a per-output direction code can exchange the roles of set and clear while the chosen counter half counts down. Every fired event also latches a sticky flag, and the flags are cleared by writing ones. The interrupt is a registered OR of the flags whose enable bits are set. Software can preset the output levels while the counter is halted. The event generator and the counter sit outside this block: it receives one-cycle event pulses and direction levels from them.

Configuration writes use a 4-bit address. Addresses 0..3 hold the set masks of outputs 0..3, and addresses 4..7 hold their clear masks. Address 8 holds the direction codes, 9 the interrupt enables, 10 the output preset, and 11 the flag-clear strobe.

Top module: `evm_top`

## Requirements
- R1: After reset, all outputs, flags and the interrupt are 0. All masks, direction codes and enables are also 0.
- R2: An event that is in output n's set mask (address n, bit e = event e) drives out_o[n] to 1 after the clock edge that samples the event.
- R3: An event that is in output n's clear mask (address 4+n) drives out_o[n] to 0 after the clock edge that samples the event.
- R4: Each output reacts to any event in its masks. A single event acts on every output whose mask contains it.
- R5: If set and clear hit the same output in one cycle, after direction handling, that output toggles.
- R6: Direction field bits [2n+1:2n] of address 8 control output n. Code 1 swaps set and clear while cnt_down_l_i is 1. Code 2 swaps them while cnt_down_h_i is 1. Codes 0 and 3 never swap.
- R7: Every event e sets flags_o[e] after the sampling edge. A flag stays set until it is cleared.
- R8: Writing to address 11 clears the flags whose data bits are 1. An event on the same cycle as the clear keeps its flag set.
- R9: irq_o is 1 exactly one cycle after some flag and its enable bit (address 9) are both 1.
- R10: A write to address 10 loads out_o from data bits [3:0] only while halted_i is 1. Such a load takes priority over events in the same cycle. While halted_i is 0, the write has no effect.
- R11: An output that is hit by no event and no accepted preset keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Fired-event pulses, one bit per event |
| cnt_down_l_i | input | 1 | Low/unified counter is counting down |
| cnt_down_h_i | input | 1 | High counter is counting down |
| halted_i | input | 1 | Counter is halted; enables output preset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration address |
| cfg_wdata_i | input | 8 | Configuration write data |
| out_o | output | 4 | Timer output levels |
| flags_o | output | 6 | Sticky event flags |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong mask, direction code or preset value shows at out_o in the cycle after the event that uses it. Every output is compared after each single-event pulse. A flag that is lost or stuck shows at flags_o one cycle after the event or the clear. A wrong enable or OR term shows at irq_o one cycle later. The sweep covers every event, mask membership, direction code, both direction levels and both starting levels, so any fault in the per-output decision appears within one pulse of the case that reaches it.

// File: rtl/evm_pkg.sv
package evm_pkg;
  typedef enum logic [1:0] {
    DIR_NONE   = 2'd0,
    DIR_SWAP_L = 2'd1,
    DIR_SWAP_H = 2'd2,
    DIR_RSVD   = 2'd3
  } dir_mode_e;

  localparam int ADDR_CLR_BASE = 4;
  localparam int ADDR_DIR      = 8;
  localparam int ADDR_IRQ_EN   = 9;
  localparam int ADDR_PRESET   = 10;
  localparam int ADDR_FLAG_CLR = 11;
endpackage

// File: rtl/evm_cfg_regs.sv
module evm_cfg_regs
  import evm_pkg::*;
#(
  parameter int N_EVT = 6,
  parameter int N_OUT = 4,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic                        halted_i,
  output logic [N_OUT-1:0][N_EVT-1:0] set_mask_o,
  output logic [N_OUT-1:0][N_EVT-1:0] clr_mask_o,
  output logic [N_OUT-1:0][1:0]       dir_o,
  output logic [N_EVT-1:0]            irq_en_o,
  output logic                        load_o,
  output logic [N_OUT-1:0]            load_val_o,
  output logic [N_EVT-1:0]            flag_clr_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  for (genvar n = 0; n < N_OUT; n++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        set_mask_o[n] <= '0;
        clr_mask_o[n] <= '0;
      end else if (we_i) begin
        if (addr_i == AW'(n))                 set_mask_o[n] <= wdata_i[N_EVT-1:0];
        if (addr_i == AW'(ADDR_CLR_BASE + n)) clr_mask_o[n] <= wdata_i[N_EVT-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o    <= '0;
      irq_en_o <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(ADDR_DIR))    dir_o    <= wdata_i[2*N_OUT-1:0];
      if (addr_i == AW'(ADDR_IRQ_EN)) irq_en_o <= wdata_i[N_EVT-1:0];
    end
  end

  // preset is only honoured while the counter is halted
  assign load_o     = we_i && halted_i && (addr_i == AW'(ADDR_PRESET));
  assign load_val_o = wdata_i[N_OUT-1:0];
  assign flag_clr_o = (we_i && addr_i == AW'(ADDR_FLAG_CLR)) ? wdata_i[N_EVT-1:0] : '0;
endmodule

// File: rtl/evm_out_cell.sv
module evm_out_cell
  import evm_pkg::*;
#(
  parameter int N_EVT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] set_mask_i,
  input  logic [N_EVT-1:0] clr_mask_i,
  input  logic [1:0]       dir_i,
  input  logic             down_l_i,
  input  logic             down_h_i,
  input  logic             load_i,
  input  logic             load_val_i,
  output logic             out_o
);
  logic set_hit, clr_hit, swap, do_set, do_clr;

  assign set_hit = |(evt_i & set_mask_i);
  assign clr_hit = |(evt_i & clr_mask_i);
  assign swap    = (dir_mode_e'(dir_i) == DIR_SWAP_L && down_l_i) ||
                   (dir_mode_e'(dir_i) == DIR_SWAP_H && down_h_i);
  assign do_set  = swap ? clr_hit : set_hit;
  assign do_clr  = swap ? set_hit : clr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                out_o <= 1'b0;
    else if (load_i)            out_o <= load_val_i;
    else if (do_set && do_clr)  out_o <= ~out_o;
    else if (do_set)            out_o <= 1'b1;
    else if (do_clr)            out_o <= 1'b0;
  end

  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(|(evt_i & (set_mask_i | clr_mask_i)))) |=> $stable(out_o));
  // R6
  down_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dir_i == 2'd1 && down_l_i && set_hit && !clr_hit) |=> !out_o);
  // R5
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && set_hit && clr_hit) |=> (out_o != $past(out_o)));
endmodule

// File: rtl/evm_irq.sv
module evm_irq #(
  parameter int N_EVT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] clr_i,
  input  logic [N_EVT-1:0] en_i,
  output logic [N_EVT-1:0] flags_o,
  output logic             irq_o
);
  // a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= (flags_o & ~clr_i) | evt_i;
      irq_o   <= |(flags_o & en_i);
    end
  end

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
  // R8
  flag_evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));
  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o & en_i) == '0) |=> !irq_o);
endmodule

// File: rtl/evm_top.sv
module evm_top
  import evm_pkg::*;
#(
  parameter int N_EVT = 6,
  parameter int N_OUT = 4,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             cnt_down_l_i,
  input  logic             cnt_down_h_i,
  input  logic             halted_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic [N_OUT-1:0] out_o,
  output logic [N_EVT-1:0] flags_o,
  output logic             irq_o
);
  logic [N_OUT-1:0][N_EVT-1:0] set_mask, clr_mask;
  logic [N_OUT-1:0][1:0]       dir;
  logic [N_EVT-1:0]            irq_en, flag_clr;
  logic                        load;
  logic [N_OUT-1:0]            load_val;

  evm_cfg_regs #(.N_EVT(N_EVT), .N_OUT(N_OUT), .AW(AW), .DW(DW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .halted_i,
    .set_mask_o(set_mask), .clr_mask_o(clr_mask), .dir_o(dir),
    .irq_en_o(irq_en), .load_o(load), .load_val_o(load_val), .flag_clr_o(flag_clr)
  );

  for (genvar n = 0; n < N_OUT; n++) begin : g_out
    evm_out_cell #(.N_EVT(N_EVT)) u_cell (
      .clk_i, .rst_ni, .evt_i,
      .set_mask_i(set_mask[n]), .clr_mask_i(clr_mask[n]), .dir_i(dir[n]),
      .down_l_i(cnt_down_l_i), .down_h_i(cnt_down_h_i),
      .load_i(load), .load_val_i(load_val[n]), .out_o(out_o[n])
    );
  end

  evm_irq #(.N_EVT(N_EVT)) u_irq (
    .clk_i, .rst_ni, .evt_i, .clr_i(flag_clr), .en_i(irq_en),
    .flags_o, .irq_o
  );

  // R10
  preset_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == AW'(ADDR_PRESET) && !halted_i && evt_i == '0) |=> $stable(out_o));
endmodule

// File: tb/tb_evm_top.sv
module tb_evm_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt = '0;
  logic       dl = 1'b0, dh = 1'b0, halted = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] out;
  logic [5:0] flags;
  logic       irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evm_top dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cnt_down_l_i(dl), .cnt_down_h_i(dh),
    .halted_i(halted), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .out_o(out), .flags_o(flags), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic preset(input logic [3:0] v);
    halted = 1'b1; wr(10, {4'h0, v}); halted = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 out", {4'h0, out}, 8'h0);
    chk("R1 flags", {2'b0, flags}, 8'h0);
    chk("R1 irq", {7'b0, irq}, 8'h0);
    rst_n = 1'b1;
    pulse(6'h3f);
    chk("R1 masks zero, out hold (R11)", {4'h0, out}, 8'h0);

    // R2 R3 R5 R6 sweep
    for (int e = 0; e < 6; e++)
      for (int m = 0; m < 4; m++)
        for (int d = 0; d < 4; d++)
          for (int dd = 0; dd < 4; dd++)
            for (int iv = 0; iv < 2; iv++) begin
              logic s, c, sw, ex;
              s = m[0]; c = m[1];
              for (int n = 0; n < 4; n++) begin
                wr(n, s ? 8'(1 << e) : 8'h0);
                wr(4 + n, c ? 8'(1 << e) : 8'h0);
              end
              wr(8, {4{d[1:0]}});
              preset(iv[0] ? 4'hf : 4'h0);
              dl = dd[0]; dh = dd[1];
              sw = (d == 1 && dd[0]) || (d == 2 && dd[1]);
              if (sw) begin logic t; t = s; s = c; c = t; end
              if (s && c) ex = ~iv[0];
              else if (s) ex = 1'b1;
              else if (c) ex = 1'b0;
              else ex = iv[0];
              pulse(6'(1 << e));
              if (s && c)         chk("R5 toggle", {4'h0, out}, {4'h0, {4{ex}}});
              else if (sw)        chk("R6 swap", {4'h0, out}, {4'h0, {4{ex}}});
              else if (s)         chk("R2 set", {4'h0, out}, {4'h0, {4{ex}}});
              else if (c)         chk("R3 clear", {4'h0, out}, {4'h0, {4{ex}}});
              else                chk("R11 hold", {4'h0, out}, {4'h0, {4{ex}}});
              dl = 1'b0; dh = 1'b0;
            end

    // R4 many-to-many
    wr(8, 8'h00);
    wr(0, 8'b001010); wr(1, 8'b001000); wr(2, 8'h00); wr(3, 8'b000001);
    wr(4, 8'h00); wr(5, 8'h00); wr(6, 8'b001000); wr(7, 8'h00);
    preset(4'b0100);
    pulse(6'b001000);
    chk("R4 one event many outputs", {4'h0, out}, 8'b0011);
    pulse(6'b000010);
    chk("R4 second event same output", {4'h0, out}, 8'b0011);
    pulse(6'b000001);
    chk("R4 other output", {4'h0, out}, 8'b1011);

    // R10 preset ignored when running
    wr(10, 8'h04);
    chk("R10 ignored", {4'h0, out}, 8'b1011);
    // R10 preset beats event
    halted = 1'b1;
    @(negedge clk); we = 1'b1; addr = 4'd10; wdata = 8'h00; evt = 6'b001000;
    @(negedge clk); we = 1'b0; evt = '0; halted = 1'b0;
    chk("R10 priority", {4'h0, out}, 8'h00);

    // R7 R8 R9
    wr(11, 8'h3f);
    wr(9, 8'h00);
    chk("R7 cleared", {2'b0, flags}, 8'h00);
    pulse(6'b000100);
    chk("R7 flag set", {2'b0, flags}, 8'h04);
    @(negedge clk);
    chk("R7 sticky", {2'b0, flags}, 8'h04);
    chk("R9 disabled", {7'b0, irq}, 8'h0);
    wr(9, 8'h04);
    @(negedge clk);
    chk("R9 raised", {7'b0, irq}, 8'h1);
    wr(11, 8'h04);
    chk("R8 w1c", {2'b0, flags}, 8'h00);
    @(negedge clk);
    chk("R9 dropped", {7'b0, irq}, 8'h0);
    pulse(6'b010001);
    wr(11, 8'h01);
    chk("R8 selective", {2'b0, flags}, 8'h10);
    @(negedge clk); we = 1'b1; addr = 4'd11; wdata = 8'h10; evt = 6'b010000;
    @(negedge clk); we = 1'b0; evt = '0;
    chk("R8 event wins", {2'b0, flags}, 8'h10);
    wr(9, 8'h10);
    @(negedge clk);
    chk("R9 other enable", {7'b0, irq}, 8'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule